// File: doc/BRIEF.md
# Serial Controller Host Register Interface

This block is the host-facing register file of an eight-register serial controller. A host reaches the registers through a 3-bit offset with separate read and write strobes; reads return data combinationally on `rdata` while `rd_en` is high, and every side effect of a read or write (clearing status, acknowledging an interrupt, loading a byte) takes place at the rising clock edge on which the strobe is sampled.

The serial shifter sits outside. It hands in each received byte with its parity and framing flags on a one-cycle `rx_valid` pulse. It takes the transmit byte from `tx_data` while `tx_full` is high and reports that it has done so with a `tx_take` pulse. A modem-line watcher presents the current modem status byte and pulses `modem_evt` when something changed. The block ranks the four interrupt conditions, publishes the winner as a code in the identification register, and drives one interrupt line gated by a modem-control bit. Offsets 0 and 1 can be switched over to a 16-bit clock divisor by the top bit of the format register.

Top module: `serial_host_regs`

## Requirements
- R1: After reset the identification register (offset 2) reads 0x01, line status (offset 5) reads 0x20, format, enable, modem control and scratch read 0x00, `tx_full` is low and `irq` is low.
- R2: Offsets are: 0 receive/transmit data, 1 interrupt enable, 2 identification (read only), 3 format, 4 modem control, 5 line status, 6 modem status, 7 scratch; scratch stores any written byte and returns it with no side effect on any other register.
- R3: While format bit 7 is 1, offset 0 and offset 1 read and write the low and high byte of `divisor`; such writes do not load the transmit byte and do not change the interrupt enable register.
- R4: The format register reads back as written; its bits drive `line_cfg` as bits[1:0] word length minus 5, bit2 two stop bits, bit3 parity on, bit4 even parity, bit5 stick parity, bit6 break.
- R5: Modem control keeps bits 4:0 (reading 0 above them) and drives `modem_ctl`; when bit3 is 0, `irq` stays low even with an interrupt pending.
- R6: `rx_valid` stores `rx_data` and sets line status bit0; a data read returns the byte and clears bit0; a byte arriving while bit0 is set raises bit1 (overrun); `rx_parity_err` sets bit2 and `rx_frame_err` sets bit3.
- R7: A read of line status clears bits 3:1 and leaves bit0 and bit5 unchanged.
- R8: A data write loads `tx_data`, raises `tx_full` and clears line status bit5; `tx_take` while full lowers `tx_full` and sets bit5.
- R9: Enable bits are bit0 received data, bit1 transmit empty, bit2 line status errors, bit3 modem status; the identification register reports only the highest enabled pending source, in the order line status 0x06, received data 0x04, transmit empty 0x02, modem status 0x00, and reads 0x01 when none is pending.
- R10: The transmit-empty condition is raised by `tx_take` or by an enable write with bit1 set while the holding register is empty, and is cleared by a data write or by an identification read that reports code 0x02.
- R11: `modem_evt` raises the modem status condition; a read of offset 6 returns `modem_lines` and clears that condition.
- R12: `irq` is high exactly when modem control bit3 is 1 and the identification register shows a pending source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rx_valid | input | 1 | Received byte pulse |
| rx_data | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error with this byte |
| rx_frame_err | input | 1 | Framing error with this byte |
| tx_data | output | 8 | Transmit holding byte |
| tx_full | output | 1 | Transmit holding byte is valid |
| tx_take | input | 1 | Shifter consumed the holding byte |
| modem_lines | input | 8 | Current modem status byte |
| modem_evt | input | 1 | Modem status change pulse |
| line_cfg | output | 7 | Format bits 6:0 |
| divisor | output | 16 | Baud clock divisor |
| modem_ctl | output | 5 | Modem control bits |
| irq | output | 1 | Interrupt line |

## Verification
The embedded assertions watch, cycle by cycle, the local cause-and-effect rules: an arriving byte sets the ready flag, a data read alone clears it, a status read with no new error empties the error bits, a data write fills the holding register, scratch keeps what was written, and divisor-bank writes leave the enable register alone. The ranking among several simultaneous interrupt sources, the acknowledge-by-identification-read of the transmit-empty source, the gating of the interrupt line and the overrun when two bytes arrive unread can only be shown by the bench's ordered scenarios, which stack all four sources and then retire them one by one.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int IEN_W  = 4;
  localparam int MCTL_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_FMT   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR   = 3'd7;

  typedef enum logic [3:0] {
    ID_MODEM = 4'h0,
    ID_NONE  = 4'h1,
    ID_TXE   = 4'h2,
    ID_RXD   = 4'h4,
    ID_LINE  = 4'h6
  } ident_e;
endpackage

// File: rtl/ser_rx_status.sv
module ser_rx_status
  import serial_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic              rd_data,
  input  logic              rd_lstat,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ready,
  output logic              overrun,
  output logic              par_err,
  output logic              frm_err
);
  logic [BYTE_W-1:0] byte_nx;
  logic ready_nx, ovr_nx, par_nx, frm_nx;

  always_comb begin
    byte_nx  = rx_byte;
    ready_nx = ready;
    ovr_nx   = overrun;
    par_nx   = par_err;
    frm_nx   = frm_err;
    if (rd_data)  ready_nx = 1'b0;
    if (rd_lstat) begin
      ovr_nx = 1'b0;
      par_nx = 1'b0;
      frm_nx = 1'b0;
    end
    if (rx_valid) begin
      byte_nx  = rx_data;
      ready_nx = 1'b1;
      if (ready)         ovr_nx = 1'b1;
      if (rx_parity_err) par_nx = 1'b1;
      if (rx_frame_err)  frm_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      ready   <= 1'b0;
      overrun <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      rx_byte <= byte_nx;
      ready   <= ready_nx;
      overrun <= ovr_nx;
      par_err <= par_nx;
      frm_err <= frm_nx;
    end
  end

  assert_rx_sets_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> ready);
  assert_data_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_valid) |=> !ready);
  assert_lstat_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lstat && !rx_valid) |=> !(overrun || par_err || frm_err));
endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold
  import serial_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tx_take,
  input  logic              ien_txe_set,
  input  logic              ident_ack,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              full,
  output logic              txe_pend
);
  logic [BYTE_W-1:0] byte_nx;
  logic full_nx, pend_nx;

  always_comb begin
    byte_nx = tx_byte;
    full_nx = full;
    pend_nx = txe_pend;
    if (tx_take && full) begin
      full_nx = 1'b0;
      pend_nx = 1'b1;
    end
    if (ien_txe_set && !full) pend_nx = 1'b1;
    if (ident_ack) pend_nx = 1'b0;
    if (wr_data) begin
      byte_nx = wdata;
      full_nx = 1'b1;
      pend_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte  <= '0;
      full     <= 1'b0;
      txe_pend <= 1'b0;
    end else begin
      tx_byte  <= byte_nx;
      full     <= full_nx;
      txe_pend <= pend_nx;
    end
  end

  assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (full && !txe_pend && tx_byte == $past(wdata)));
  assert_take_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && full && !wr_data && !ident_ack) |=> (!full && txe_pend));
endmodule

// File: rtl/ser_irq_rank.sv
module ser_irq_rank
  import serial_regs_pkg::*;
(
  input  logic [IEN_W-1:0] ien,
  input  logic             line_cond,
  input  logic             rxd_cond,
  input  logic             txe_cond,
  input  logic             modem_cond,
  output ident_e           ident,
  output logic             pending
);
  logic [IEN_W-1:0] live;

  assign live = ien & {modem_cond, line_cond, txe_cond, rxd_cond};

  always_comb begin
    if (live[2])      ident = ID_LINE;
    else if (live[0]) ident = ID_RXD;
    else if (live[1]) ident = ID_TXE;
    else if (live[3]) ident = ID_MODEM;
    else              ident = ID_NONE;
  end

  assign pending = |live;

  always_comb begin
    assert_ident_bit0_R9: assert (pending == (ident != ID_NONE));
  end
endmodule

// File: rtl/serial_host_regs.sv
module serial_host_regs
  import serial_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              tx_take,
  input  logic [BYTE_W-1:0] modem_lines,
  input  logic              modem_evt,
  output logic [BYTE_W-2:0] line_cfg,
  output logic [2*BYTE_W-1:0] divisor,
  output logic [MCTL_W-1:0] modem_ctl,
  output logic              irq
);
  localparam int BANK_BIT = BYTE_W - 1;
  localparam int GATE_BIT = 3;
  localparam int TXE_BIT  = 1;

  logic [IEN_W-1:0]  ien_q, ien_nx;
  logic [BYTE_W-1:0] fmt_q, fmt_nx;
  logic [MCTL_W-1:0] mctl_q, mctl_nx;
  logic [BYTE_W-1:0] scr_q, scr_nx;
  logic [BYTE_W-1:0] dlo_q, dlo_nx, dhi_q, dhi_nx;
  logic              mpend_q, mpend_nx;

  logic bank;
  logic wr_data, wr_ien, wr_dlo, wr_dhi, rd_data, rd_lstat, rd_ident, rd_mstat;
  logic ien_txe_set, ident_ack;
  logic [BYTE_W-1:0] rx_byte, lstat;
  logic rdy, ovr, perr, ferr, full, txe_pend, pending;
  ident_e ident;

  assign bank     = fmt_q[BANK_BIT];
  assign wr_data  = wr_en && addr == OFS_DATA && !bank;
  assign wr_dlo   = wr_en && addr == OFS_DATA &&  bank;
  assign wr_ien   = wr_en && addr == OFS_IEN  && !bank;
  assign wr_dhi   = wr_en && addr == OFS_IEN  &&  bank;
  assign rd_data  = rd_en && addr == OFS_DATA && !bank;
  assign rd_lstat = rd_en && addr == OFS_LSTAT;
  assign rd_ident = rd_en && addr == OFS_IDENT;
  assign rd_mstat = rd_en && addr == OFS_MSTAT;

  assign ien_txe_set = wr_ien && wdata[TXE_BIT];
  assign ident_ack   = rd_ident && ident == ID_TXE;

  ser_rx_status u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .rd_data(rd_data), .rd_lstat(rd_lstat),
    .rx_byte(rx_byte), .ready(rdy), .overrun(ovr),
    .par_err(perr), .frm_err(ferr)
  );

  ser_tx_hold u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_data), .wdata(wdata), .tx_take(tx_take),
    .ien_txe_set(ien_txe_set), .ident_ack(ident_ack),
    .tx_byte(tx_data), .full(full), .txe_pend(txe_pend)
  );

  ser_irq_rank u_rank (
    .ien(ien_q),
    .line_cond(ovr | perr | ferr),
    .rxd_cond(rdy),
    .txe_cond(txe_pend),
    .modem_cond(mpend_q),
    .ident(ident), .pending(pending)
  );

  assign lstat = {2'b00, ~full, 1'b0, ferr, perr, ovr, rdy};

  always_comb begin
    ien_nx   = ien_q;
    fmt_nx   = fmt_q;
    mctl_nx  = mctl_q;
    scr_nx   = scr_q;
    dlo_nx   = dlo_q;
    dhi_nx   = dhi_q;
    mpend_nx = mpend_q;
    if (wr_ien) ien_nx = wdata[IEN_W-1:0];
    if (wr_dlo) dlo_nx = wdata;
    if (wr_dhi) dhi_nx = wdata;
    if (wr_en && addr == OFS_FMT)  fmt_nx  = wdata;
    if (wr_en && addr == OFS_MCTL) mctl_nx = wdata[MCTL_W-1:0];
    if (wr_en && addr == OFS_SCR)  scr_nx  = wdata;
    if (rd_mstat)  mpend_nx = 1'b0;
    if (modem_evt) mpend_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      fmt_q   <= '0;
      mctl_q  <= '0;
      scr_q   <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      mpend_q <= 1'b0;
    end else begin
      ien_q   <= ien_nx;
      fmt_q   <= fmt_nx;
      mctl_q  <= mctl_nx;
      scr_q   <= scr_nx;
      dlo_q   <= dlo_nx;
      dhi_q   <= dhi_nx;
      mpend_q <= mpend_nx;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_DATA:  rdata = bank ? dlo_q : rx_byte;
      OFS_IEN:   rdata = bank ? dhi_q : {{(BYTE_W-IEN_W){1'b0}}, ien_q};
      OFS_IDENT: rdata = {{(BYTE_W-4){1'b0}}, ident};
      OFS_FMT:   rdata = fmt_q;
      OFS_MCTL:  rdata = {{(BYTE_W-MCTL_W){1'b0}}, mctl_q};
      OFS_LSTAT: rdata = lstat;
      OFS_MSTAT: rdata = modem_lines;
      default:   rdata = scr_q;
    endcase
  end

  assign tx_full   = full;
  assign line_cfg  = fmt_q[BYTE_W-2:0];
  assign divisor   = {dhi_q, dlo_q};
  assign modem_ctl = mctl_q;
  assign irq       = mctl_q[GATE_BIT] && pending;

  assert_scratch_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_SCR) |=> scr_q == $past(wdata));
  assert_bank_spares_ien_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank && addr == OFS_IEN) |=> $stable(ien_q));
  assert_bank_no_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank && addr == OFS_DATA && !tx_full && !tx_take) |=> !tx_full);
  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mctl_q[GATE_BIT] |-> !irq);
  assert_modem_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mstat && !modem_evt) |=> !mpend_q);
endmodule

// File: tb/serial_host_regs_test.sv
module serial_host_regs_test;
  logic clk, rst_n;
  logic [2:0] addr;
  logic wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic rx_valid, rx_parity_err, rx_frame_err, tx_full, tx_take, modem_evt, irq;
  logic [7:0] rx_data, tx_data, modem_lines;
  logic [6:0] line_cfg;
  logic [15:0] divisor;
  logic [4:0] modem_ctl;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  serial_host_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .tx_data(tx_data), .tx_full(tx_full), .tx_take(tx_take),
    .modem_lines(modem_lines), .modem_evt(modem_evt), .line_cfg(line_cfg),
    .divisor(divisor), .modem_ctl(modem_ctl), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read addr %0d: actual %02h expected %02h", t, addr, rdata, e);
        end
      end
    end
  end

  task automatic clear_strobes();
    wr_en = 0; rd_en = 0; rx_valid = 0; tx_take = 0; modem_evt = 0;
    rx_parity_err = 0; rx_frame_err = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clear_strobes();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1;
    step();
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    step();
  endtask

  task automatic rx(input logic [7:0] d, input logic pe, input logic fe);
    @(posedge clk); #1;
    rx_valid = 1; rx_data = d; rx_parity_err = pe; rx_frame_err = fe;
    step();
  endtask

  task automatic take();
    @(posedge clk); #1; tx_take = 1; step();
  endtask

  task automatic mevt();
    @(posedge clk); #1; modem_evt = 1; step();
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  logic done = 0;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; addr = 0; wdata = 0; rx_data = 0; modem_lines = 8'hB0;
    clear_strobes();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk(irq, 0, "R1 irq");
    chk(tx_full, 0, "R1 tx_full");
    rd(3'd2, 8'h01, "R1 ident");
    rd(3'd5, 8'h20, "R1 lstat");
    rd(3'd3, 8'h00, "R1 fmt");
    rd(3'd1, 8'h00, "R1 ien");
    rd(3'd4, 8'h00, "R1 mctl");
    rd(3'd7, 8'h00, "R1 scratch");

    // R2 scratch
    wr(3'd7, 8'hA5);
    rd(3'd7, 8'hA5, "R2 scratch");
    rd(3'd5, 8'h20, "R2 lstat untouched");

    // R3 divisor bank
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    chk(divisor, 16'h1234, "R3 divisor");
    chk(tx_full, 0, "R3 no tx load");
    rd(3'd0, 8'h34, "R3 div low");
    rd(3'd1, 8'h12, "R3 div high");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h00, "R3 ien untouched");
    rd(3'd3, 8'h03, "R4 fmt readback");

    // R6 receive, R5 gate, R12 irq
    rx(8'h5A, 0, 0);
    rd(3'd5, 8'h21, "R6 ready set");
    wr(3'd1, 8'h01);
    rd(3'd2, 8'h04, "R9 rx ident");
    chk(irq, 0, "R5 gate off");
    wr(3'd4, 8'h08);
    chk(irq, 1, "R12 irq on");
    rd(3'd0, 8'h5A, "R6 data");
    rd(3'd2, 8'h01, "R9 none after read");
    chk(irq, 0, "R12 irq off");
    rd(3'd5, 8'h20, "R6 ready cleared");

    // R9 ranking with all four sources
    rx(8'h11, 1, 0);
    rx(8'h22, 0, 0);
    mevt();
    wr(3'd1, 8'h0F);
    rd(3'd2, 8'h06, "R9 line first");
    rd(3'd5, 8'h27, "R7 lstat errors");
    rd(3'd2, 8'h04, "R9 rx second");
    rd(3'd0, 8'h22, "R6 overrun keeps latest");
    rd(3'd2, 8'h02, "R10 txe third");
    rd(3'd2, 8'h00, "R10 ident ack, R11 modem");
    rd(3'd6, 8'hB0, "R11 modem lines");
    rd(3'd2, 8'h01, "R11 cleared");
    chk(irq, 0, "R12 idle");

    // R8 / R10 transmit path
    wr(3'd0, 8'h77);
    chk(tx_full, 1, "R8 full");
    chk(tx_data, 8'h77, "R8 tx_data");
    rd(3'd5, 8'h00, "R8 bit5 clear");
    rd(3'd2, 8'h01, "R10 no txe while full");
    take();
    chk(tx_full, 0, "R8 taken");
    rd(3'd5, 8'h20, "R8 bit5 set");
    chk(irq, 1, "R10 irq on take");
    wr(3'd0, 8'h78);
    rd(3'd2, 8'h01, "R10 write clears");
    take();
    rd(3'd2, 8'h02, "R10 raised again");
    wr(3'd1, 8'h00);
    rd(3'd2, 8'h01, "R9 disabled");
    chk(irq, 0, "R12 disabled");

    // R6 framing, R7 keeps ready
    rx(8'h33, 0, 1);
    rd(3'd5, 8'h29, "R6 frame err");
    rd(3'd5, 8'h21, "R7 cleared keeps ready");
    rd(3'd0, 8'h33, "R6 data");

    // R4 format outputs, R5 mctl width
    wr(3'd3, 8'h5D);
    chk(line_cfg, 7'h5D, "R4 line_cfg");
    rd(3'd3, 8'h5D, "R4 fmt");
    wr(3'd4, 8'hFF);
    chk(modem_ctl, 5'h1F, "R5 modem_ctl");
    rd(3'd4, 8'h1F, "R5 mctl upper zero");

    repeat (2) @(posedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule